// File: doc/BRIEF.md
# ADC Conversion Status Flag Controller

This block keeps the five status flags of a two-group analog-to-digital converter and drives a single interrupt request from them. The conversion engine reports its progress through one-cycle event pulses. These cover the end of a sampling phase, regular data being written, injected data being written into one of four injected slots, and the last conversion of a sequence. The block turns each pulse into a sticky flag. Software clears the flags through write-one-to-clear strobes. Two of the flags also clear as a side effect of reading the matching data register.

The regular and injected groups are tracked separately. For the injected group, the block remembers which slot was written most recently. A read of an injected data register clears the injected end-of-conversion flag only when the read targets that slot. The sequence flags and the sampling flag ignore reads and clear only on a write of one. When a set event and a clear arrive in the same cycle, the set wins, so no event is lost. Each flag has its own interrupt enable. The interrupt output is registered.

Top module: `adc_flag_ctrl`

## Requirements
- R1: The flag vector `flags_o` uses this bit map: bit 0 is end of sampling, bit 1 is regular end of conversion, bit 2 is regular end of sequence, bit 3 is injected end of conversion, and bit 4 is injected end of sequence. While `rst` is high at a clock edge, every flag and `irq_o` become 0 after that edge.
- R2: A cycle with `ev_reg_data` high sets bit 1 after the clock edge.
- R3: Bit 1 clears after an edge at which `rd_reg_data` is high, or at which `w1c_valid` is high with `w1c_mask[1]` set.
- R4: A cycle with `ev_inj_data` high sets bit 3 for any value of `ev_inj_slot`. That slot is recorded as the most recent injected slot, which is 0 after reset.
- R5: Bit 3 clears after an edge at which `w1c_valid` is high with `w1c_mask[3]` set. It also clears after an edge at which `rd_inj_data` is high and `rd_inj_slot` equals the most recent injected slot recorded before that edge. A read of any other slot leaves bit 3 unchanged.
- R6: A cycle with `ev_smp_done` high sets bit 0. Bit 0 clears only on `w1c_valid` with `w1c_mask[0]`. Data reads do not affect it.
- R7: A cycle with both `ev_reg_data` and `ev_reg_last` high sets bit 2. Bit 2 clears only on `w1c_valid` with `w1c_mask[2]`.
- R8: A cycle with both `ev_inj_data` and `ev_inj_last` high sets bit 4. Bit 4 clears only on `w1c_valid` with `w1c_mask[4]`.
- R9: When a flag's set event and one of its clear conditions occur in the same cycle, the flag is 1 after the edge.
- R10: A zero bit in `w1c_mask`, or any mask while `w1c_valid` is low, leaves the matching flag unchanged.
- R11: After each clock edge, `irq_o` equals the OR over all bits of the new `flags_o` ANDed with the `irq_en` value sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_smp_done | input | 1 | End-of-sampling pulse (regular group) |
| ev_reg_data | input | 1 | Regular data written pulse |
| ev_reg_last | input | 1 | Qualifies ev_reg_data as last of the regular sequence |
| ev_inj_data | input | 1 | Injected data written pulse |
| ev_inj_slot | input | SLOT_W | Slot written by ev_inj_data |
| ev_inj_last | input | 1 | Qualifies ev_inj_data as last of the injected sequence |
| w1c_valid | input | 1 | Write strobe for the flag register |
| w1c_mask | input | NUM_FLAGS | Write-one-to-clear data |
| rd_reg_data | input | 1 | Read strobe of the regular data register |
| rd_inj_data | input | 1 | Read strobe of an injected data register |
| rd_inj_slot | input | SLOT_W | Slot being read |
| irq_en | input | NUM_FLAGS | Per-flag interrupt enables |
| flags_o | output | NUM_FLAGS | Flag vector |
| irq_o | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check several properties. A set event always shows as a set flag after the edge. The regular data read and the write-one strobe clear their flags. The sampling and sequence flags persist when no write-one targets them. No flag rises without its event. The interrupt line always agrees with the flags and the previous enables. Only the bench's scenarios can show the slot qualification of injected reads, the full mix of simultaneous events and clears, and reset values. The bench checks these through a behavioural model compared on every clock.

// File: rtl/adc_flag_pkg.sv
package adc_flag_pkg;
  localparam int NUM_FLAGS = 5;
  localparam int FLG_SMP  = 0;
  localparam int FLG_EOC  = 1;
  localparam int FLG_EOS  = 2;
  localparam int FLG_JEOC = 3;
  localparam int FLG_JEOS = 4;
endpackage

// File: rtl/adc_flag_cell.sv
module adc_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic q_o
);
  // set has priority over clear so no event is dropped
  always_comb nxt_o = set_i | (q_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt_o;
  end
endmodule

// File: rtl/adc_inj_slot_trk.sv
module adc_inj_slot_trk #(
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic              rd_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic              rd_hit_o
);
  logic [SLOT_W-1:0] last_slot_q;

  always_ff @(posedge clk) begin
    if (rst)       last_slot_q <= '0;
    else if (wr_i) last_slot_q <= wr_slot_i;
  end

  always_comb rd_hit_o = rd_i && (rd_slot_i == last_slot_q);
endmodule

// File: rtl/adc_irq_reg.sv
module adc_irq_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags_nxt_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(flags_nxt_i & en_i);
  end
endmodule

// File: rtl/adc_flag_ctrl.sv
module adc_flag_ctrl
  import adc_flag_pkg::*;
#(
  parameter int NUM_JSLOTS = 4,
  parameter int SLOT_W     = $clog2(NUM_JSLOTS),
  parameter int NF         = NUM_FLAGS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_smp_done,
  input  logic              ev_reg_data,
  input  logic              ev_reg_last,
  input  logic              ev_inj_data,
  input  logic [SLOT_W-1:0] ev_inj_slot,
  input  logic              ev_inj_last,
  input  logic              w1c_valid,
  input  logic [NF-1:0]     w1c_mask,
  input  logic              rd_reg_data,
  input  logic              rd_inj_data,
  input  logic [SLOT_W-1:0] rd_inj_slot,
  input  logic [NF-1:0]     irq_en,
  output logic [NF-1:0]     flags_o,
  output logic              irq_o
);
  logic [NF-1:0] set_v, clr_v, nxt_v, wr_clr;
  logic          jrd_hit;

  adc_inj_slot_trk #(.SLOT_W(SLOT_W)) trk_i (
    .clk(clk), .rst(rst),
    .wr_i(ev_inj_data), .wr_slot_i(ev_inj_slot),
    .rd_i(rd_inj_data), .rd_slot_i(rd_inj_slot),
    .rd_hit_o(jrd_hit)
  );

  always_comb begin
    wr_clr = w1c_valid ? w1c_mask : '0;
    set_v  = '0;
    set_v[FLG_SMP]  = ev_smp_done;
    set_v[FLG_EOC]  = ev_reg_data;
    set_v[FLG_EOS]  = ev_reg_data & ev_reg_last;
    set_v[FLG_JEOC] = ev_inj_data;
    set_v[FLG_JEOS] = ev_inj_data & ev_inj_last;
    clr_v = wr_clr;
    clr_v[FLG_EOC]  = wr_clr[FLG_EOC]  | rd_reg_data;
    clr_v[FLG_JEOC] = wr_clr[FLG_JEOC] | jrd_hit;
  end

  for (genvar g = 0; g < NF; g++) begin : g_cell
    adc_flag_cell cell_i (
      .clk(clk), .rst(rst),
      .set_i(set_v[g]), .clr_i(clr_v[g]),
      .nxt_o(nxt_v[g]), .q_o(flags_o[g])
    );
  end

  adc_irq_reg #(.N(NF)) irq_i (
    .clk(clk), .rst(rst),
    .flags_nxt_i(nxt_v), .en_i(irq_en),
    .irq_o(irq_o)
  );
endmodule

// File: rtl/adc_flag_ctrl_chk.sv
module adc_flag_ctrl_chk #(
  parameter int SLOT_W = 2,
  parameter int NF     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_smp_done,
  input logic              ev_reg_data,
  input logic              ev_reg_last,
  input logic              ev_inj_data,
  input logic              ev_inj_last,
  input logic              w1c_valid,
  input logic [NF-1:0]     w1c_mask,
  input logic              rd_reg_data,
  input logic [NF-1:0]     irq_en,
  input logic [NF-1:0]     flags_o,
  input logic              irq_o
);
  // R2
  eoc_set_chk: assert property (@(posedge clk) disable iff (rst)
    ev_reg_data |=> flags_o[1]);
  // R9
  jeoc_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ev_inj_data |=> flags_o[3]);
  // R3
  eoc_rd_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_reg_data && !ev_reg_data) |=> !flags_o[1]);
  // R6
  smp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_o[0] && !(w1c_valid && w1c_mask[0])) |=> flags_o[0]);
  // R10
  eos_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_o[2] && !(w1c_valid && w1c_mask[2])) |=> flags_o[2]);
  // R8
  jeos_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (w1c_valid && w1c_mask[4] && !(ev_inj_data && ev_inj_last)) |=> !flags_o[4]);
  // R7
  eos_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (!flags_o[2] && !(ev_reg_data && ev_reg_last)) |=> !flags_o[2]);
  // R11
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == |(flags_o & $past(irq_en))));
endmodule

bind adc_flag_ctrl adc_flag_ctrl_chk #(.SLOT_W(SLOT_W), .NF(NF)) chk_i (
  .clk(clk), .rst(rst), .ev_smp_done(ev_smp_done), .ev_reg_data(ev_reg_data),
  .ev_reg_last(ev_reg_last), .ev_inj_data(ev_inj_data), .ev_inj_last(ev_inj_last),
  .w1c_valid(w1c_valid), .w1c_mask(w1c_mask), .rd_reg_data(rd_reg_data),
  .irq_en(irq_en), .flags_o(flags_o), .irq_o(irq_o)
);

// File: tb/adc_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_flag_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_smp_done = 0, ev_reg_data = 0, ev_reg_last = 0;
  logic ev_inj_data = 0, ev_inj_last = 0;
  logic [1:0] ev_inj_slot = '0, rd_inj_slot = '0;
  logic w1c_valid = 0, rd_reg_data = 0, rd_inj_data = 0;
  logic [4:0] w1c_mask = '0, irq_en = '0;
  logic [4:0] flags_o;
  logic irq_o;

  int vectors = 0, fails = 0;
  bit [4:0] m_flags = '0;
  bit m_irq = 0;
  int m_last = 0;

  always #10 clk = ~clk;

  adc_flag_ctrl dut_i (
    .clk(clk), .rst(rst), .ev_smp_done(ev_smp_done), .ev_reg_data(ev_reg_data),
    .ev_reg_last(ev_reg_last), .ev_inj_data(ev_inj_data), .ev_inj_slot(ev_inj_slot),
    .ev_inj_last(ev_inj_last), .w1c_valid(w1c_valid), .w1c_mask(w1c_mask),
    .rd_reg_data(rd_reg_data), .rd_inj_data(rd_inj_data), .rd_inj_slot(rd_inj_slot),
    .irq_en(irq_en), .flags_o(flags_o), .irq_o(irq_o)
  );

  function automatic string bit_req(int b);
    case (b)
      0: return "R6"; 1: return "R3"; 2: return "R7"; 3: return "R5"; default: return "R8";
    endcase
  endfunction

  // behavioural model of one clock edge, from the requirement text
  task automatic model_edge();
    bit [4:0] s, c, wm;
    if (rst) begin m_flags = '0; m_irq = 0; m_last = 0; return; end
    wm = w1c_valid ? w1c_mask : 5'b0;
    s = {ev_inj_data && ev_inj_last, ev_inj_data, ev_reg_data && ev_reg_last,
         ev_reg_data, ev_smp_done};
    c = wm;
    if (rd_reg_data) c[1] = 1;
    if (rd_inj_data && int'(rd_inj_slot) == m_last) c[3] = 1;
    for (int b = 0; b < 5; b++) m_flags[b] = s[b] | (m_flags[b] & ~c[b]);
    if (ev_inj_data) m_last = int'(ev_inj_slot);
    m_irq = |(m_flags & irq_en);
  endtask

  task automatic compare(string tag);
    for (int b = 0; b < 5; b++) begin
      vectors++;
      if (flags_o[b] !== m_flags[b]) begin
        fails++;
        $display("FAIL %s/%s flag bit %0d actual %b expected %b", tag, bit_req(b), b, flags_o[b], m_flags[b]);
      end
    end
    vectors++;
    if (irq_o !== m_irq) begin
      fails++;
      $display("FAIL %s/R11 irq actual %b expected %b", tag, irq_o, m_irq);
    end
  endtask

  // inputs already driven; advance one edge and check at the next falling edge
  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    ev_smp_done = 0; ev_reg_data = 0; ev_reg_last = 0; ev_inj_data = 0;
    ev_inj_last = 0; w1c_valid = 0; w1c_mask = '0; rd_reg_data = 0; rd_inj_data = 0;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    ev_smp_done = 1; ev_reg_data = 1; irq_en = '1;
    step("R1"); step("R1");           // reset beats events
    idle(); rst = 0;
    step("R1");
    ev_reg_data = 1; step("R2"); idle();
    rd_inj_data = 1; rd_inj_slot = 0; step("R6"); idle();   // read leaves EOC
    rd_reg_data = 1; step("R3"); idle();
    ev_smp_done = 1; step("R6"); idle();
    rd_reg_data = 1; rd_inj_data = 1; step("R6"); idle();
    w1c_valid = 1; w1c_mask = 5'b11110; step("R10"); idle();
    w1c_valid = 0; w1c_mask = 5'b00001; step("R10"); idle();
    w1c_valid = 1; w1c_mask = 5'b00001; step("R6"); idle();
    ev_reg_data = 1; ev_reg_last = 1; step("R7"); idle();
    rd_reg_data = 1; step("R7"); idle();
    w1c_valid = 1; w1c_mask = 5'b00110; step("R7"); idle();
    ev_inj_data = 1; ev_inj_slot = 2; step("R4"); idle();
    rd_inj_data = 1; rd_inj_slot = 1; step("R5"); idle();
    rd_inj_data = 1; rd_inj_slot = 2; step("R5"); idle();
    ev_inj_data = 1; ev_inj_slot = 3; ev_inj_last = 1; step("R8"); idle();
    rd_inj_data = 1; rd_inj_slot = 3; step("R8"); idle();
    w1c_valid = 1; w1c_mask = 5'b10000; step("R8"); idle();
    ev_reg_data = 1; rd_reg_data = 1; step("R9"); idle();
    ev_inj_data = 1; ev_inj_slot = 0; rd_inj_data = 1; rd_inj_slot = 3;
    w1c_valid = 1; w1c_mask = '1; step("R9"); idle();
    irq_en = 5'b00000; step("R11");
    irq_en = 5'b01000; step("R11");
    w1c_valid = 1; w1c_mask = '1; step("R11"); idle();
    for (int i = 0; i < 3000; i++) begin
      ev_smp_done = ($urandom_range(0, 5) == 0);
      ev_reg_data = ($urandom_range(0, 3) == 0);
      ev_reg_last = $urandom_range(0, 1) == 1;
      ev_inj_data = ($urandom_range(0, 3) == 0);
      ev_inj_slot = 2'($urandom_range(0, 3));
      ev_inj_last = $urandom_range(0, 1) == 1;
      w1c_valid = ($urandom_range(0, 3) == 0);
      w1c_mask = 5'($urandom_range(0, 31));
      rd_reg_data = ($urandom_range(0, 3) == 0);
      rd_inj_data = ($urandom_range(0, 2) == 0);
      rd_inj_slot = 2'($urandom_range(0, 3));
      irq_en = 5'($urandom_range(0, 31));
      rst = ($urandom_range(0, 499) == 0);
      step("mix");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule